// File: doc/BRIEF.md
# Dual-Lane Double-Edge Serial Capture Master

This block is a serial master for a peripheral that puts a new data bit on its output at every rising edge and every falling edge of the serial clock. Two receive lanes share one serial clock and one active-low chip select, and they are captured in parallel. Each lane carries the data for one half of the peripheral's channels. A command word is shifted out on the transmit line during the same word.

A start request pulls chip select low and waits a setup interval. The block then runs the serial clock for one word, sampling both lanes on every half-period. It returns chip select high and presents both received words with a one-cycle valid strobe. Chip select then stays high for a guard interval before the next word can begin. The setup and guard intervals are given in picoseconds and converted to whole system cycles from the clock frequency parameter. A request that arrives while a word or the guard interval is in progress is held and launched as soon as the guard interval ends.

Top module: `ddr_spi_capture`

## Requirements
- R1: After a synchronous active-high reset, chip select is high, the serial clock is low, the transmit line is low and valid is low.
- R2: A start request in the idle state pulls chip select low on the next cycle, and the first serial clock rise follows exactly SETUP_CYC + HALF_DIV system cycles after chip select falls. SETUP_CYC is the smallest whole number of system cycles not shorter than 20.8 ns (2 at 50 MHz).
- R3: The serial clock is low whenever chip select is high. Each word has exactly WORD_W serial clock edges (WORD_W/2 rising), and each half-period lasts HALF_DIV system cycles.
- R4: Both lanes are sampled in the last system cycle of every half-period, so data is taken on both edges. The bit taken in half-period h (h = 0 is the half-period before the first rising edge) becomes bit WORD_W-1-h of that lane's word, so the first bit lands in the MSB.
- R5: The command on cmd_i is captured with the accepted start request. During half-period h the transmit line carries command bit WORD_W-1-h, MSB first.
- R6: Valid is a single-cycle pulse in the same cycle that chip select returns high. Lane A's word appears on word_a_o and lane B's word on word_b_o.
- R7: Chip select returns high after every word and stays high for at least IDLE_CYC system cycles before it falls again. IDLE_CYC is the smallest whole number of system cycles not shorter than 154 ns (8 at 50 MHz).
- R8: A start request that arrives during a word or during the guard interval is held. Chip select falls again in the cycle right after the guard interval, so it is high for exactly IDLE_CYC cycles.
- R9: Only one request is held at a time. Further start pulses while a request is held are dropped, and the held request keeps its own command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run a word |
| cmd_i | input | WORD_W | Command word, captured with start_i |
| miso_a_i | input | 1 | Receive lane A |
| miso_b_i | input | 1 | Receive lane B |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Transmit line, command MSB first |
| word_a_o | output | WORD_W | Last word received on lane A |
| word_b_o | output | WORD_W | Last word received on lane B |
| valid_o | output | 1 | One-cycle strobe when both words are updated |

## Verification
The bench models the peripheral, which changes both lanes on every serial clock edge. A design that sampled on only one edge, or that shifted LSB first, returns scrambled words, and unlike patterns on the two lanes expose swapped or merged lanes. It measures the cycles from chip select falling to the first rising edge and the high time between words. A request held during a word and one held during the guard interval must both launch with exactly the minimum gap, so a design that waits an extra idle cycle or cuts the gap short is caught. A third start pulse while one request is already held must not produce an extra word or overwrite the held command, which the count of valid strobes and the command recovered from the transmit line reveal.

// File: rtl/ddr_spi_pkg.sv
package ddr_spi_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_SHIFT,
        PH_GAP
    } phase_e;

    // smallest whole number of clock cycles covering min_ps, never below one
    function automatic int unsigned min_cycles(input longint unsigned min_ps,
                                               input longint unsigned clk_hz);
        longint unsigned num;
        num = min_ps * clk_hz + 64'd999_999_999_999;
        num = num / 64'd1_000_000_000_000;
        if (num == 64'd0) begin
            num = 64'd1;
        end
        return 32'(num);
    endfunction

endpackage

// File: rtl/ddr_spi_lane.sv
module ddr_spi_lane #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_i,
    input  logic              last_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] shift_d, shift_q;
    logic [WORD_W-1:0] hold_d,  hold_q;

    always_comb begin
        shift_d = shift_q;
        hold_d  = hold_q;
        if (sample_i) begin
            // first bit of a word walks up to the MSB
            shift_d = {shift_q[WORD_W-2:0], bit_i};
            if (last_i) begin
                hold_d = shift_d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            hold_q  <= '0;
        end else begin
            shift_q <= shift_d;
            hold_q  <= hold_d;
        end
    end

    assign word_o = hold_q;

endmodule

// File: rtl/ddr_spi_tx.sv
module ddr_spi_tx #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              step_i,
    output logic              mosi_o
);

    logic [WORD_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = cmd_i;
        end else if (step_i) begin
            // zeros fill in, so the line rests low after the last bit
            sh_d = {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi_o = sh_q[WORD_W-1];

endmodule

// File: rtl/ddr_spi_capture.sv
module ddr_spi_capture
    import ddr_spi_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned SETUP_PS = 20_800,
    parameter int unsigned IDLE_PS  = 154_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cmd_i,
    input  logic              miso_a_i,
    input  logic              miso_b_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic [WORD_W-1:0] word_a_o,
    output logic [WORD_W-1:0] word_b_o,
    output logic              valid_o
);

    localparam int unsigned SETUP_CYC = min_cycles(64'(SETUP_PS), 64'(CLK_HZ));
    localparam int unsigned IDLE_CYC  = min_cycles(64'(IDLE_PS),  64'(CLK_HZ));
    localparam int unsigned CNT_MAX0  = (IDLE_CYC > SETUP_CYC) ? IDLE_CYC : SETUP_CYC;
    localparam int unsigned CNT_MAX   = (CNT_MAX0 > HALF_DIV) ? CNT_MAX0 : HALF_DIV;
    localparam int          CNT_W     = $clog2(CNT_MAX + 1);
    localparam int          BIT_W     = $clog2(WORD_W);
    localparam int          LANES     = 2;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitidx;
        logic              sclk;
        logic              cs_n;
        logic              valid;
        logic              pend;
        logic [WORD_W-1:0] pend_cmd;
    } ctl_t;

    ctl_t r_q, r_d;

    logic              load;
    logic [WORD_W-1:0] load_cmd;
    logic              sample;
    logic              last;

    always_comb begin
        r_d        = r_q;
        r_d.valid  = 1'b0;
        load       = 1'b0;
        load_cmd   = cmd_i;
        sample     = 1'b0;
        last       = 1'b0;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load      = 1'b1;
                    load_cmd  = cmd_i;
                    r_d.cs_n  = 1'b0;
                    r_d.phase = PH_SETUP;
                    r_d.cnt   = CNT_W'(SETUP_CYC - 1);
                end
            end

            PH_SETUP: begin
                if (start_i && !r_q.pend) begin
                    r_d.pend     = 1'b1;
                    r_d.pend_cmd = cmd_i;
                end
                if (r_q.cnt == '0) begin
                    r_d.phase  = PH_SHIFT;
                    r_d.cnt    = CNT_W'(HALF_DIV - 1);
                    r_d.bitidx = '0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end

            PH_SHIFT: begin
                if (start_i && !r_q.pend) begin
                    r_d.pend     = 1'b1;
                    r_d.pend_cmd = cmd_i;
                end
                if (r_q.cnt == '0) begin
                    // end of a half-period: sample, then move the clock edge
                    sample   = 1'b1;
                    r_d.sclk = ~r_q.sclk;
                    r_d.cnt  = CNT_W'(HALF_DIV - 1);
                    if (r_q.bitidx == BIT_W'(WORD_W - 1)) begin
                        last      = 1'b1;
                        r_d.valid = 1'b1;
                        r_d.cs_n  = 1'b1;
                        r_d.phase = PH_GAP;
                        r_d.cnt   = CNT_W'(IDLE_CYC - 1);
                    end else begin
                        r_d.bitidx = r_q.bitidx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end

            PH_GAP: begin
                if (r_q.cnt == '0) begin
                    if (r_q.pend || start_i) begin
                        load      = 1'b1;
                        load_cmd  = r_q.pend ? r_q.pend_cmd : cmd_i;
                        r_d.pend  = 1'b0;
                        r_d.cs_n  = 1'b0;
                        r_d.phase = PH_SETUP;
                        r_d.cnt   = CNT_W'(SETUP_CYC - 1);
                    end else begin
                        r_d.phase = PH_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (start_i && !r_q.pend) begin
                        r_d.pend     = 1'b1;
                        r_d.pend_cmd = cmd_i;
                    end
                end
            end

            default: begin
                r_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.phase    <= PH_IDLE;
            r_q.cs_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    ddr_spi_tx #(
        .WORD_W (WORD_W)
    ) u_tx (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .cmd_i  (load_cmd),
        .step_i (sample),
        .mosi_o (mosi_o)
    );

    logic [LANES-1:0]  lane_in;
    logic [WORD_W-1:0] lane_word [LANES];

    assign lane_in = {miso_b_i, miso_a_i};

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        ddr_spi_lane #(
            .WORD_W (WORD_W)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .sample_i (sample),
            .last_i   (last),
            .bit_i    (lane_in[gi]),
            .word_o   (lane_word[gi])
        );
    end

    assign word_a_o = lane_word[0];
    assign word_b_o = lane_word[1];
    assign cs_n_o   = r_q.cs_n;
    assign sclk_o   = r_q.sclk;
    assign valid_o  = r_q.valid;

endmodule

// File: rtl/ddr_spi_capture_chk.sv
module ddr_spi_capture_chk
    import ddr_spi_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned SETUP_PS = 20_800,
    parameter int unsigned IDLE_PS  = 154_000
) (
    input logic clk,
    input logic rst,
    input logic cs_n_o,
    input logic sclk_o,
    input logic valid_o
);

    localparam int unsigned SETUP_CYC = min_cycles(64'(SETUP_PS), 64'(CLK_HZ));
    localparam int unsigned IDLE_CYC  = min_cycles(64'(IDLE_PS),  64'(CLK_HZ));
    localparam logic [15:0] FIRST_EDGE = 16'(SETUP_CYC + HALF_DIV);
    localparam logic [15:0] GAP_MIN    = 16'(IDLE_CYC);
    localparam logic [15:0] EDGES      = 16'(WORD_W);

    logic [15:0] lo_cnt_q, hi_cnt_q, edge_q, edges_now;
    logic        sclk_prev_q;

    assign edges_now = edge_q + {15'd0, (sclk_o != sclk_prev_q)};

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt_q    <= '0;
            hi_cnt_q    <= GAP_MIN;
            edge_q      <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= sclk_o;
            edge_q      <= cs_n_o ? 16'd0 : edges_now;
            lo_cnt_q    <= cs_n_o ? 16'd0 : ((lo_cnt_q == 16'hFFFF) ? lo_cnt_q : lo_cnt_q + 16'd1);
            hi_cnt_q    <= !cs_n_o ? 16'd0 : ((hi_cnt_q == 16'hFFFF) ? hi_cnt_q : hi_cnt_q + 16'd1);
        end
    end

    // R3
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    // R3
    edge_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> edges_now == EDGES);

    // R2
    setup_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && sclk_o && !sclk_prev_q && edge_q == 16'd0) |-> lo_cnt_q == FIRST_EDGE);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6
    valid_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(cs_n_o));

    // R7
    gap_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> hi_cnt_q >= GAP_MIN);

endmodule

bind ddr_spi_capture ddr_spi_capture_chk #(
    .CLK_HZ   (CLK_HZ),
    .WORD_W   (WORD_W),
    .HALF_DIV (HALF_DIV),
    .SETUP_PS (SETUP_PS),
    .IDLE_PS  (IDLE_PS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .valid_o (valid_o)
);

// File: tb/ddr_spi_capture_bench.sv
`timescale 1ns/1ps
module ddr_spi_capture_bench;

    localparam int W          = 16;
    localparam int HD         = 2;
    localparam int PERIOD_PS  = 20_000;
    localparam int SETUP_EXP  = (20_800 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int IDLE_EXP   = (154_000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int FIRST_EXP  = SETUP_EXP + HD;

    typedef struct {
        logic [W-1:0] cmd;
        logic [W-1:0] a;
        logic [W-1:0] b;
        bit           tight;
    } item_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [W-1:0] cmd_i;
    logic         miso_a_i;
    logic         miso_b_i;
    logic         cs_n_o;
    logic         sclk_o;
    logic         mosi_o;
    logic [W-1:0] word_a_o;
    logic [W-1:0] word_b_o;
    logic         valid_o;

    always #10 clk = ~clk;

    ddr_spi_capture u_ddr_spi_capture (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .cmd_i    (cmd_i),
        .miso_a_i (miso_a_i),
        .miso_b_i (miso_b_i),
        .cs_n_o   (cs_n_o),
        .sclk_o   (sclk_o),
        .mosi_o   (mosi_o),
        .word_a_o (word_a_o),
        .word_b_o (word_b_o),
        .valid_o  (valid_o)
    );

    int    checks = 0;
    int    fails  = 0;
    int    pushed = 0;
    int    seen   = 0;
    bit    finished = 0;
    item_t stim_q[$];
    item_t exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one start pulse, expectations go into the scoreboard
    task automatic request(input logic [W-1:0] c, input logic [W-1:0] a,
                           input logic [W-1:0] b, input bit tight);
        item_t it;
        it.cmd = c; it.a = a; it.b = b; it.tight = tight;
        @(negedge clk);
        cmd_i   = c;
        start_i = 1'b1;
        stim_q.push_back(it);
        exp_q.push_back(it);
        pushed++;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic stray_start(input logic [W-1:0] c);
        @(negedge clk);
        cmd_i   = c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0 || stim_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // peripheral model and monitor, both on the falling system edge
    logic         prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0, prev_valid = 1'b0;
    int           idx = 0, edges = 0, lo_cnt = 0, hi_cnt = 1000;
    logic [W-1:0] rx_cmd = '0;
    item_t        cur;

    always @(negedge clk) begin
        if (rst) begin
            prev_cs = 1'b1; prev_sclk = 1'b0; prev_mosi = 1'b0; prev_valid = 1'b0;
            hi_cnt = 1000; miso_a_i = 1'b0; miso_b_i = 1'b0;
        end else begin
            if (prev_cs && !cs_n_o) begin
                if (stim_q.size() == 0) begin
                    chk(1'b0, "R9 word without request", 32'(pushed), 32'(seen));
                    cur.cmd = '0; cur.a = '0; cur.b = '0; cur.tight = 1'b0;
                end else begin
                    cur = stim_q.pop_front();
                    if (cur.tight)
                        chk(hi_cnt == IDLE_EXP, "R8 held start gap", 32'(hi_cnt), 32'(IDLE_EXP));
                    else
                        chk(hi_cnt >= IDLE_EXP, "R7 minimum gap", 32'(hi_cnt), 32'(IDLE_EXP));
                end
                idx = 0; edges = 0; lo_cnt = 1; rx_cmd = '0;
            end else if (!cs_n_o) begin
                lo_cnt++;
            end
            if (sclk_o != prev_sclk) begin
                if (edges == 0)
                    chk(lo_cnt - 1 == FIRST_EXP, "R2 first edge delay", 32'(lo_cnt - 1), 32'(FIRST_EXP));
                rx_cmd = {rx_cmd[W-2:0], prev_mosi};
                edges++;
                idx++;
            end
            if (!prev_cs && cs_n_o) begin
                chk(edges == W, "R3 edges per word", 32'(edges), 32'(W));
                chk(rx_cmd == cur.cmd, "R5 command on mosi", 32'(rx_cmd), 32'(cur.cmd));
                hi_cnt = 0;
            end
            if (cs_n_o) begin
                hi_cnt++;
                chk(sclk_o == 1'b0, "R3 clock low while deselected", 32'(sclk_o), 32'd0);
            end
            if (valid_o) begin
                chk(!prev_cs && cs_n_o, "R6 valid with release", 32'(cs_n_o), 32'd1);
                chk(!prev_valid, "R6 valid one cycle", 32'(prev_valid), 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 extra valid", 32'(seen + 1), 32'(pushed));
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(word_a_o == e.a, "R4 lane A word", 32'(word_a_o), 32'(e.a));
                    chk(word_b_o == e.b, "R6 lane B word", 32'(word_b_o), 32'(e.b));
                end
                seen++;
            end
            if (!cs_n_o && idx < W) begin
                miso_a_i = cur.a[W-1-idx];
                miso_b_i = cur.b[W-1-idx];
            end else begin
                miso_a_i = 1'b0;
                miso_b_i = 1'b0;
            end
            prev_cs = cs_n_o; prev_sclk = sclk_o; prev_mosi = mosi_o; prev_valid = valid_o;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; cmd_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n_o == 1'b1, "R1 cs after reset", 32'(cs_n_o), 32'd1);
        chk(sclk_o == 1'b0, "R1 sclk after reset", 32'(sclk_o), 32'd0);
        chk(mosi_o == 1'b0, "R1 mosi after reset", 32'(mosi_o), 32'd0);
        chk(valid_o == 1'b0, "R1 valid after reset", 32'(valid_o), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // single words, distinct lane patterns
        request(16'hA5C3, 16'hF00F, 16'h0001, 1'b0);
        wait_idle();
        request(16'h0000, 16'hFFFF, 16'h0000, 1'b0);
        wait_idle();
        request(16'hFFFF, 16'h8000, 16'h7FFE, 1'b0);
        wait_idle();

        // R8 request held during a word
        request(16'h8001, 16'hAAAA, 16'h5555, 1'b0);
        repeat (10) @(negedge clk);
        request(16'h1357, 16'h2468, 16'h9BDF, 1'b1);
        wait_idle();

        // R8 request held during the guard interval
        request(16'h4C2D, 16'h0F0F, 16'hC3C3, 1'b0);
        while (!valid_o) @(negedge clk);
        repeat (2) @(negedge clk);
        request(16'hB6E1, 16'h1248, 16'hEDB7, 1'b1);
        wait_idle();

        // R9 a second pulse while one is held is dropped
        request(16'h7E81, 16'h3C3C, 16'h6996, 1'b0);
        repeat (5) @(negedge clk);
        request(16'hD00D, 16'hCAFE, 16'hBEEF, 1'b1);
        repeat (3) @(negedge clk);
        stray_start(16'h2BAD);
        wait_idle();
        repeat (40) @(negedge clk);

        chk(seen == pushed, "R9 word count", 32'(seen), 32'(pushed));
        chk(exp_q.size() == 0, "R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule